// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This controller owns the writable part of a serial memory's status register and decides whether a status write may go ahead. A command decoder upstream gives it single-cycle pulses for a write-enable command and for a complete status-write frame. Each status-write pulse comes with the received data byte and a flag that says whether the frame had the correct length. The controller also watches the external active-low write-protect pin and the chip-select line. It launches an internal write cycle only when chip select is released after an accepted request. It holds a busy flag for a fixed number of system clocks, commits the new nonvolatile bits when the cycle finishes, and clears the write-enable latch at that point.

The pin can only protect the register when the write-protect-enable bit, which is one of the nonvolatile bits, is 1. When that bit is 0 the pin is ignored, so a board with the pin tied low can still write the register. The accept or refuse decision and the data are frozen when the cycle launches. After that, changes on chip select or on the pin do not affect the running write. The standby indication stays low until a running cycle completes, even if chip select is already high.

Top module: `swp_ctrl`

## Requirements
- R1: After reset, status_o reads 0x00, busy_o and wel_o are 0, and standby_o is 1 while cs_ni is high. The status byte layout is: bit 0 busy, bit 1 write-enable latch, bits 2, 3 and 7 nonvolatile, with bit 7 the protect-enable bit. All other bits read 0.
- R2: A write-enable pulse while not busy sets the write-enable latch, which shows as status bit 1.
- R3: When the protect-enable bit is 0, an accepted status write commits the data's nonvolatile bits even with wp_ni low. Data bits outside the nonvolatile set (0x8C) are ignored.
- R4: When the protect-enable bit is 1 and wp_ni is low at the request, the write is refused. No cycle starts, the nonvolatile bits are unchanged, and the latch keeps its value.
- R5: When wp_ni is high, a status write proceeds whatever the protect-enable bit holds, and it may clear that bit.
- R6: An internal cycle starts only on the chip-select low-to-high transition that follows an accepted request. Before that transition, busy_o stays 0 and the status bits do not change.
- R7: busy_o stays high for exactly BUSY_CYCLES clocks. The nonvolatile bits take their new value in the same cycle that busy_o falls, and the latch clears in that cycle.
- R8: After a cycle launches, wp_ni going low or chip select toggling has no effect, and the launched data is committed.
- R9: standby_o is high only when chip select is high and no cycle is running. If chip select is high during a cycle, standby_o stays low until the cycle completes.
- R10: A status write whose frame flag is 0 is discarded. No cycle starts and the status bits are unchanged.
- R11: A status write while the latch is clear is ignored.
- R12: While busy, new write-enable and status-write requests are ignored, and a chip-select rising edge does not start a second cycle.
- R13: When the protect-enable bit is 1, wp_ni going low at any point between the request and the chip-select release refuses the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select, synchronized inside |
| wp_ni | input | 1 | Active-low write-protect pin |
| wren_cmd_i | input | 1 | Decoded write-enable command pulse |
| sr_wr_req_i | input | 1 | Decoded status-write frame pulse |
| sr_frame_ok_i | input | 1 | Frame length of the status write was correct |
| sr_data_i | input | SR_W | Data byte of the status write |
| status_o | output | SR_W | Readable status byte |
| busy_o | output | 1 | Internal write cycle running |
| wel_o | output | 1 | Write-enable latch |
| standby_o | output | 1 | Deselected and idle |

## Verification
The bench targets the corners of the protect decision. It writes with the pin low while protect-enable is 0; a design that ignores that bit would refuse this write. It drops the pin only after the request but before chip select rises; a design that samples the pin just once would accept that write. It drops the pin and toggles chip select during a running cycle; a design whose decision is not frozen would lose the committed data. It also sends a short frame, a request with the latch clear, and a request during busy. The bench counts every busy pulse against the pulses it expects, so a spurious or duplicate launch shows up even when the final status happens to look right.

// File: rtl/swp_pkg.sv
package swp_pkg;
   localparam int SR_W = 8;

   typedef struct packed {
      logic            refuse;
      logic [SR_W-1:0] data;
   } sr_job_t;
endpackage

// File: rtl/swp_cs_sync.sv
module swp_cs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cs_ni,
   output logic cs_high_o,
   output logic cs_rise_o
);
   logic cs_lvl;
   logic cs_prev;

   generate
      if (STAGES == 0) begin : g_direct
         assign cs_lvl = cs_ni;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '1;
            else if (STAGES == 1) chain_q <= cs_ni;
            else chain_q <= {chain_q[STAGES-2:0], cs_ni};
         end
         assign cs_lvl = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cs_prev <= 1'b1;
      else cs_prev <= cs_lvl;
   end

   assign cs_high_o = cs_lvl;
   assign cs_rise_o = cs_lvl & ~cs_prev;
endmodule

// File: rtl/swp_guard.sv
module swp_guard
   import swp_pkg::*;
(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            cs_high_i,
   input  logic            cs_rise_i,
   input  logic            wp_ni,
   input  logic            wpen_i,
   input  logic            wel_i,
   input  logic            busy_i,
   input  logic            req_i,
   input  logic            frame_ok_i,
   input  logic [SR_W-1:0] data_i,
   output logic            launch_o,
   output sr_job_t         job_o
);
   logic    pend_q;
   sr_job_t job_q;
   logic    pin_block;

   assign pin_block = wpen_i & ~wp_ni;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= 1'b0;
         job_q  <= '0;
      end else if (cs_rise_i) begin
         pend_q       <= 1'b0;
         job_q.refuse <= 1'b0;
      end else if (req_i) begin
         pend_q      <= frame_ok_i & wel_i & ~busy_i;
         job_q.refuse <= pin_block;
         job_q.data   <= data_i;
      end else if (pend_q && !cs_high_i && pin_block) begin
         job_q.refuse <= 1'b1;
      end
   end

   assign launch_o = cs_rise_i & pend_q & ~job_q.refuse & ~busy_i;
   assign job_o    = job_q;
endmodule

// File: rtl/swp_cycle_timer.sv
module swp_cycle_timer #(
   parameter int BUSY_CYCLES = 20,
   localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else if (start_i && cnt_q == '0) cnt_q <= CNT_W'(BUSY_CYCLES);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/swp_ctrl.sv
module swp_ctrl
   import swp_pkg::*;
#(
   parameter int            BUSY_CYCLES = 20,
   parameter int            CS_SYNC     = 2,
   parameter logic [SR_W-1:0] NV_MASK   = 8'h8C,
   parameter logic [SR_W-1:0] NV_RESET  = 8'h00,
   parameter int            WPEN_BIT    = 7,
   parameter int            WEL_BIT     = 1,
   parameter int            BUSY_BIT    = 0
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            cs_ni,
   input  logic            wp_ni,
   input  logic            wren_cmd_i,
   input  logic            sr_wr_req_i,
   input  logic            sr_frame_ok_i,
   input  logic [SR_W-1:0] sr_data_i,
   output logic [SR_W-1:0] status_o,
   output logic            busy_o,
   output logic            wel_o,
   output logic            standby_o
);
   generate
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least 1");
      end
      if (!NV_MASK[WPEN_BIT]) begin : g_bad_wpen
         $error("protect-enable bit must be nonvolatile");
      end
      if (NV_MASK[WEL_BIT] || NV_MASK[BUSY_BIT] || WEL_BIT == BUSY_BIT) begin : g_bad_flags
         $error("flag bits overlap");
      end
   endgenerate

   logic            cs_high, cs_rise;
   logic            launch, done, busy;
   sr_job_t         pend_job;
   logic [SR_W-1:0] nv_q, commit_q;
   logic            wel_q;

   swp_cs_sync #(.STAGES(CS_SYNC)) cs_sync_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cs_ni    (cs_ni),
      .cs_high_o(cs_high),
      .cs_rise_o(cs_rise)
   );

   swp_guard guard_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cs_high_i (cs_high),
      .cs_rise_i (cs_rise),
      .wp_ni     (wp_ni),
      .wpen_i    (nv_q[WPEN_BIT]),
      .wel_i     (wel_q),
      .busy_i    (busy),
      .req_i     (sr_wr_req_i),
      .frame_ok_i(sr_frame_ok_i),
      .data_i    (sr_data_i),
      .launch_o  (launch),
      .job_o     (pend_job)
   );

   swp_cycle_timer #(.BUSY_CYCLES(BUSY_CYCLES)) timer_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(launch),
      .busy_o (busy),
      .done_o (done)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         commit_q <= '0;
         nv_q     <= NV_RESET & NV_MASK;
         wel_q    <= 1'b0;
      end else begin
         if (launch) commit_q <= pend_job.data & NV_MASK;
         if (done) nv_q <= commit_q;
         if (done) wel_q <= 1'b0;
         else if (wren_cmd_i && !busy) wel_q <= 1'b1;
      end
   end

   always_comb begin
      status_o           = nv_q;
      status_o[WEL_BIT]  = wel_q;
      status_o[BUSY_BIT] = busy;
   end

   assign busy_o    = busy;
   assign wel_o     = wel_q;
   assign standby_o = cs_high & ~busy;
endmodule

// File: rtl/swp_ctrl_chk.sv
module swp_ctrl_chk
   import swp_pkg::*;
#(
   parameter int              BUSY_CYCLES = 20,
   parameter logic [SR_W-1:0] NV_MASK     = 8'h8C
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic [SR_W-1:0] status_o,
   input logic            busy_o,
   input logic            wel_o
);
   int busy_run;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) busy_run <= 0;
      else if (busy_o) busy_run <= busy_run + 1;
      else busy_run <= 0;
   end

   a_r7_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> busy_run == BUSY_CYCLES);

   a_r7_wel_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> !wel_o);

   a_r2_launch_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> $past(wel_o));

   a_r6_nv_only_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$fell(busy_o) |-> $stable(status_o & NV_MASK));
endmodule

bind swp_ctrl swp_ctrl_chk #(.BUSY_CYCLES(BUSY_CYCLES), .NV_MASK(NV_MASK)) chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .status_o(status_o),
   .busy_o  (busy_o),
   .wel_o   (wel_o)
);

// File: tb/swp_ctrl_tb_top.sv
module swp_ctrl_tb_top;
   localparam int BUSY = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, wp_n = 1'b1, wren = 1'b0, req = 1'b0, fok = 1'b0;
   logic [7:0] din = 8'h00;
   logic [7:0] status;
   logic       busy, wel, stby;

   int total = 0, bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   int         blen_q[$];
   int         run = 0;

   always #2 clk = ~clk;

   swp_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wp_ni(wp_n),
      .wren_cmd_i(wren), .sr_wr_req_i(req), .sr_frame_ok_i(fok),
      .sr_data_i(din), .status_o(status), .busy_o(busy), .wel_o(wel),
      .standby_o(stby)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // status scoreboard monitor
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(status === e, t, status, e);
      end
   end

   // busy pulse monitor: every pulse must be expected and of the right length
   always @(negedge clk) begin
      if (busy === 1'b1) run++;
      else if (run > 0) begin
         if (blen_q.size() == 0) chk(1'b0, "R12 unexpected busy pulse", run, 0);
         else begin
            int e;
            e = blen_q.pop_front();
            chk(run == e, "R7 busy length", run, e);
         end
         run = 0;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic expect_status(input logic [7:0] v, input string t);
      exp_q.push_back(v);
      tag_q.push_back(t);
      idle(1);
   endtask
   task automatic sel();
      cs_n = 1'b0; idle(4);
   endtask
   task automatic desel();
      cs_n = 1'b1; idle(5);
   endtask
   task automatic do_wren();
      sel(); wren = 1'b1; idle(1); wren = 1'b0; desel();
   endtask
   task automatic send_req(input logic [7:0] d, input logic ok);
      din = d; fok = ok; req = 1'b1; idle(1); req = 1'b0; fok = 1'b0;
   endtask
   task automatic finish_cycle();
      idle(BUSY + 4);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      expect_status(8'h00, "R1 reset status");
      chk(busy === 1'b0 && wel === 1'b0, "R1 flags", {busy, wel}, 0);
      chk(stby === 1'b1, "R1 standby", stby, 1);

      // R11 status write without latch
      sel(); send_req(8'h8C, 1'b1); desel();
      expect_status(8'h00, "R11 ignored without latch");

      // R2 latch set
      do_wren();
      expect_status(8'h02, "R2 latch set");

      // R3 / R6 / R9 write with protect-enable 0 and pin low
      wp_n = 1'b0;
      sel(); send_req(8'hFF, 1'b1); idle(3);
      chk(busy === 1'b0, "R6 no busy before cs rise", busy, 0);
      expect_status(8'h02, "R6 unchanged before cs rise");
      blen_q.push_back(BUSY);
      cs_n = 1'b1; idle(4);
      chk(busy === 1'b1, "R6 busy after cs rise", busy, 1);
      chk(stby === 1'b0, "R9 no standby while busy", stby, 0);
      expect_status(8'h03, "R7 old bits during cycle");
      finish_cycle();
      expect_status(8'h8C, "R3 pin ignored, R7 latch cleared");
      chk(stby === 1'b1, "R9 standby after cycle", stby, 1);

      // R4 refused with protect-enable 1 and pin low
      do_wren();
      sel(); send_req(8'h00, 1'b1); desel(); finish_cycle();
      expect_status(8'h8E, "R4 refused write");

      // R5 pin high, write clears protect-enable
      wp_n = 1'b1;
      blen_q.push_back(BUSY);
      sel(); send_req(8'h04, 1'b1); desel(); finish_cycle();
      expect_status(8'h04, "R5 pin high write");
      do_wren();
      blen_q.push_back(BUSY);
      sel(); send_req(8'h88, 1'b1); desel(); finish_cycle();
      expect_status(8'h88, "R5 set protect-enable");

      // R13 pin pulse low after request, before release
      do_wren();
      sel(); send_req(8'h00, 1'b1);
      wp_n = 1'b0; idle(2); wp_n = 1'b1; idle(2);
      desel(); finish_cycle();
      expect_status(8'h8A, "R13 late pin low refuses");

      // R8 pin low and cs toggling during a cycle
      blen_q.push_back(BUSY);
      sel(); send_req(8'h80, 1'b1); cs_n = 1'b1; idle(5);
      wp_n = 1'b0; cs_n = 1'b0; idle(3); cs_n = 1'b1; idle(2);
      chk(stby === 1'b0, "R9 standby held low with cs high", stby, 0);
      finish_cycle();
      wp_n = 1'b1;
      expect_status(8'h80, "R8 launched write completes");

      // R10 bad frame
      do_wren();
      sel(); send_req(8'h8C, 1'b0); desel(); finish_cycle();
      expect_status(8'h82, "R10 short frame discarded");

      // R12 requests during busy
      blen_q.push_back(BUSY);
      sel(); send_req(8'h08, 1'b1); desel();
      sel(); wren = 1'b1; idle(1); wren = 1'b0;
      send_req(8'h84, 1'b1); desel();
      finish_cycle(); idle(BUSY);
      expect_status(8'h08, "R12 second request ignored");

      idle(4);
      chk(blen_q.size() == 0, "R7 all expected cycles seen", blen_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule